// File: doc/BRIEF.md
# XOR-Coded Speculative Output Port

This block is one output port of a switch, fed by several input ports. Each cycle it looks at the inputs that are requesting. When exactly one requests, that flit goes onto the output link unchanged. When two or more contend, the port does not stall. It puts the bitwise XOR of every contending flit on the link and flags the word as coded. In the same cycle a round-robin arbiter picks one contender. That contender is acknowledged and leaves the contention set. The next cycle carries the XOR of the contenders that remain. This repeats until one contender is left, and that flit is sent plain as the last word of the sequence.

A receiver-side decoder is included in the same top. It is fed by the link registers and recovers the original flits. It XORs each word of a coded sequence with the word that follows it, so the flits come out in the order the arbiter granted them. Plain words that are not part of a sequence pass straight through. Requests that arrive while a sequence is in progress are held off until the set has drained. After each coded sequence the port leaves the link idle for one cycle, so the decoder can release the last flit of the sequence.

Top module: `xsp_port`

## Requirements
- R1: When exactly one input is valid outside a sequence, that input is acknowledged in the same cycle. Its flit appears on the link on the next cycle with `linkValid`=1, `linkCoded`=0 and `linkData` equal to the flit. A source that keeps one input loaded is served on consecutive cycles.
- R2: When two or more inputs are live, the next link word has `linkCoded`=1 and `linkData` equal to the bitwise XOR of the flits of all live inputs.
- R3: In every cycle that produces a link word, exactly one input is acknowledged, and it is a valid input. In a sequence, the acknowledged input is left out of every later word, so each word equals the previous word XOR the flit of the previous winner.
- R4: A sequence goes on until one contender remains. That contender's flit is sent as the final word with `linkCoded`=0. The link is then idle for exactly one cycle before any new word.
- R5: The winner is the first live input found at or after the round-robin pointer, scanning upward with wraparound. After every acknowledge the pointer moves to the index just above the winner, wrapping to 0. Reset sets the pointer to 0.
- R6: An input that becomes valid while a sequence is in progress is not acknowledged until that sequence and its idle cycle are over. It is then served as a new request.
- R7: The decoder emits every flit of a coded sequence with `outValid`=1, in grant order and with its original value. A coded word does not produce an output in the cycle it is received. Each recovered flit is emitted one cycle after the link word that completes it, and the final flit follows one cycle after that.
- R8: A plain link word that is not part of a sequence appears on `outData` with `outValid`=1 one cycle after it is on the link.
- R9: During and right after reset, `linkValid`, `outValid` and every bit of `inAck` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | NUM_IN | Per-input request; held high with stable data until acknowledged |
| inData | input | NUM_IN*FLIT_W | Flits of all inputs, input i at bits [i*FLIT_W +: FLIT_W] |
| inAck | output | NUM_IN | One-hot acknowledge; the input drops or replaces its flit after the edge |
| linkValid | output | 1 | Link word present (registered) |
| linkCoded | output | 1 | Link word is the XOR of two or more flits |
| linkData | output | FLIT_W | Link word |
| outValid | output | 1 | Decoder has a recovered flit |
| outData | output | FLIT_W | Recovered flit |

## Verification
The port is tried with a lone requester, with two, three and four simultaneous contenders, and with one input loaded with several flits back to back. Each contention case checks the exact XOR word on the link, the grant order and the decoded flits. These cases separate the XOR encoding from the arbiter masking and from the decoder's pairwise recovery. One scenario raises a new request in the middle of a sequence. It shows whether late inputs are held off and whether the idle cycle after the final word is kept. Contention patterns are repeated with the round-robin pointer at different positions, which separates a true rotation from a fixed priority.

// File: rtl/xsp_pkg.sv
package xsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DRAIN = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic send;   // a link word is produced this cycle
    logic coded;  // two or more contenders are merged
  } linkStrobe_t;

endpackage

// File: rtl/xsp_ctrl.sv
module xsp_ctrl
  import xsp_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] inValid,
  output logic [NUM_IN-1:0] inAck,
  output logic [NUM_IN-1:0] liveMask,
  output linkStrobe_t       strb
);

  localparam int PW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam int CW = $clog2(NUM_IN + 1);

  seqState_e         state;
  logic [NUM_IN-1:0] setMask;
  logic [PW-1:0]     rrPtr;

  logic [CW-1:0]     liveCount;
  logic              found;
  logic [PW-1:0]     winIdx;

  always_comb begin
    case (state)
      ST_IDLE: liveMask = inValid;
      ST_BUSY: liveMask = setMask & inValid;
      default: liveMask = '0;
    endcase
  end

  always_comb begin
    liveCount = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      liveCount = liveCount + CW'(liveMask[i]);
    end
  end

  // round-robin search from the pointer upward
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int k = 0; k < NUM_IN; k++) begin
      int idx;
      idx = int'(rrPtr) + k;
      if (idx >= NUM_IN) idx = idx - NUM_IN;
      if (!found && liveMask[idx]) begin
        found  = 1'b1;
        winIdx = idx[PW-1:0];
      end
    end
  end

  always_comb begin
    inAck = '0;
    if (found) inAck[winIdx] = 1'b1;
    strb.send  = found;
    strb.coded = (liveCount > CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      setMask <= '0;
      rrPtr   <= '0;
    end else begin
      if (found) begin
        rrPtr <= (int'(winIdx) == NUM_IN - 1) ? '0 : winIdx + PW'(1);
      end
      case (state)
        ST_IDLE: begin
          if (strb.coded) begin
            state   <= ST_BUSY;
            setMask <= liveMask & ~inAck;
          end
        end
        ST_BUSY: begin
          if (strb.coded) begin
            setMask <= liveMask & ~inAck;
          end else begin
            setMask <= '0;
            state   <= found ? ST_DRAIN : ST_IDLE;
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inAck)); // R3
  AST_ACK_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (inAck & ~inValid) == '0); // R3
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> ((inAck & ~setMask) == '0)); // R6
  AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |-> (inAck == '0)); // R4

endmodule

// File: rtl/xsp_dpath.sv
module xsp_dpath
  import xsp_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int FLIT_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN*FLIT_W-1:0] inData,
  input  logic [NUM_IN-1:0]        liveMask,
  input  linkStrobe_t              strb,
  output logic                     linkValid,
  output logic                     linkCoded,
  output logic [FLIT_W-1:0]        linkData
);

  logic [FLIT_W-1:0] xorAcc;

  always_comb begin
    xorAcc = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (liveMask[i]) xorAcc = xorAcc ^ inData[i*FLIT_W +: FLIT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkValid <= 1'b0;
      linkCoded <= 1'b0;
      linkData  <= '0;
    end else begin
      linkValid <= strb.send;
      linkCoded <= strb.send & strb.coded;
      linkData  <= xorAcc;
    end
  end

  AST_CODED_MULTI: assert property (@(posedge clk) disable iff (!rstN)
    strb.coded |-> ($countones(liveMask) >= 2)); // R2
  AST_SEQ_CONTINUES: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && linkCoded) |=> linkValid); // R4

endmodule

// File: rtl/xsp_decoder.sv
module xsp_decoder #(
  parameter int FLIT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkValid,
  input  logic              linkCoded,
  input  logic [FLIT_W-1:0] linkData,
  output logic              outValid,
  output logic [FLIT_W-1:0] outData
);

  logic [FLIT_W-1:0] held;
  logic              heldOn;
  logic              heldLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held     <= '0;
      heldOn   <= 1'b0;
      heldLast <= 1'b0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= 1'b0;
      if (heldLast) begin
        outValid <= 1'b1;
        outData  <= held;
        heldOn   <= 1'b0;
        heldLast <= 1'b0;
      end else if (linkValid) begin
        if (heldOn) begin
          outValid <= 1'b1;
          outData  <= held ^ linkData;
          held     <= linkData;
          heldLast <= !linkCoded;
        end else if (linkCoded) begin
          held   <= linkData;
          heldOn <= 1'b1;
        end else begin
          outValid <= 1'b1;
          outData  <= linkData;
        end
      end
    end
  end

  AST_GAP_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rstN)
    heldLast |-> !linkValid); // R4
  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && !linkCoded && !heldOn) |=> (outValid && outData == $past(linkData))); // R8
  AST_CODED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && linkCoded && !heldOn) |=> !outValid); // R7

endmodule

// File: rtl/xsp_port.sv
module xsp_port
  import xsp_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int FLIT_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [NUM_IN*FLIT_W-1:0] inData,
  output logic [NUM_IN-1:0]        inAck,
  output logic                     linkValid,
  output logic                     linkCoded,
  output logic [FLIT_W-1:0]        linkData,
  output logic                     outValid,
  output logic [FLIT_W-1:0]        outData
);

  linkStrobe_t       strb;
  logic [NUM_IN-1:0] liveMask;

  xsp_ctrl #(.NUM_IN(NUM_IN)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inAck    (inAck),
    .liveMask (liveMask),
    .strb     (strb)
  );

  xsp_dpath #(.NUM_IN(NUM_IN), .FLIT_W(FLIT_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .liveMask  (liveMask),
    .strb      (strb),
    .linkValid (linkValid),
    .linkCoded (linkCoded),
    .linkData  (linkData)
  );

  xsp_decoder #(.FLIT_W(FLIT_W)) dec_i (
    .clk       (clk),
    .rstN      (rstN),
    .linkValid (linkValid),
    .linkCoded (linkCoded),
    .linkData  (linkData),
    .outValid  (outValid),
    .outData   (outData)
  );

endmodule

// File: tb/xsp_port_tb.sv
module xsp_port_tb_top;

  localparam int N = 4;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  inValid = '0;
  logic [N*W-1:0] inData = '0;
  logic [N-1:0]  inAck;
  logic          linkValid, linkCoded, outValid;
  logic [W-1:0]  linkData, outData;

  always #5 clk = ~clk;

  xsp_port #(.NUM_IN(N), .FLIT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inAck(inAck),
    .linkValid(linkValid), .linkCoded(linkCoded), .linkData(linkData),
    .outValid(outValid), .outData(outData)
  );

  int errors = 0;
  int checks = 0;
  int cycle = 0;

  // source queues per input
  logic [W-1:0] mem [N][8];
  int wrIdx [N];
  int rdIdx [N];
  int cnt   [N];
  logic [N-1:0] ackS = '0;

  // recorded activity
  logic [W-1:0] linkQ[$];
  logic         codedQ[$];
  int           linkCyc[$];
  logic [W-1:0] outQ[$];
  int           outCyc[$];
  int           ackQ[$];
  int           ackCyc[$];

  // expected activity
  logic [W-1:0] expLink[$];
  logic         expCoded[$];
  logic [W-1:0] expOut[$];
  int           expAck[$];
  int           mPtr = 0;
  logic [W-1:0] curD [N];

  always @(posedge clk) cycle <= cycle + 1;

  always @(negedge clk) begin
    ackS = inAck;
    if (rstN) begin
      if (linkValid) begin
        linkQ.push_back(linkData); codedQ.push_back(linkCoded); linkCyc.push_back(cycle);
      end
      if (outValid) begin
        outQ.push_back(outData); outCyc.push_back(cycle);
      end
      for (int i = 0; i < N; i++) begin
        if (inAck[i]) begin ackQ.push_back(i); ackCyc.push_back(cycle); end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    for (int i = 0; i < N; i++) begin
      if (ackS[i] && cnt[i] > 0) begin
        rdIdx[i] = rdIdx[i] + 1;
        cnt[i] = cnt[i] - 1;
      end
      inValid[i] = (cnt[i] > 0);
      inData[i*W +: W] = mem[i][rdIdx[i] % 8];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int i, input logic [W-1:0] d);
    mem[i][wrIdx[i] % 8] = d;
    wrIdx[i] = wrIdx[i] + 1;
    cnt[i] = cnt[i] + 1;
  endtask

  task automatic clearAll();
    linkQ.delete(); codedQ.delete(); linkCyc.delete();
    outQ.delete(); outCyc.delete(); ackQ.delete(); ackCyc.delete();
    expLink.delete(); expCoded.delete(); expOut.delete(); expAck.delete();
  endtask

  // model of one contention group starting together (R2 R3 R4 R5 R7)
  task automatic addGroup(input logic [N-1:0] mask);
    int ord[$];
    logic [N-1:0] m;
    m = mask;
    while (m != '0) begin
      bit got;
      got = 0;
      for (int k = 0; k < N; k++) begin
        int idx;
        idx = (mPtr + k) % N;
        if (!got && m[idx]) begin
          got = 1; ord.push_back(idx); m[idx] = 1'b0; mPtr = (idx + 1) % N;
        end
      end
    end
    for (int j = 0; j < ord.size(); j++) begin
      logic [W-1:0] x;
      x = '0;
      for (int t = j; t < ord.size(); t++) x = x ^ curD[ord[t]];
      expLink.push_back(x);
      expCoded.push_back((ord.size() - j) >= 2);
      expOut.push_back(curD[ord[j]]);
      expAck.push_back(ord[j]);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(linkQ.size() == expLink.size(), {tag, " R2 link word count"}, linkQ.size(), expLink.size());
    for (int j = 0; j < linkQ.size() && j < expLink.size(); j++) begin
      chk(linkQ[j] == expLink[j], {tag, " R2 link data"}, linkQ[j], expLink[j]);
      chk(codedQ[j] == expCoded[j], {tag, " R4 coded flag"}, codedQ[j], expCoded[j]);
    end
    chk(ackQ.size() == expAck.size(), {tag, " R3 ack count"}, ackQ.size(), expAck.size());
    for (int j = 0; j < ackQ.size() && j < expAck.size(); j++)
      chk(ackQ[j] == expAck[j], {tag, " R5 grant order"}, ackQ[j], expAck[j]);
    chk(outQ.size() == expOut.size(), {tag, " R7 decoded count"}, outQ.size(), expOut.size());
    for (int j = 0; j < outQ.size() && j < expOut.size(); j++)
      chk(outQ[j] == expOut[j], {tag, " R7 decoded flit"}, outQ[j], expOut[j]);
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  task automatic startAt();
    @(negedge clk); #2;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(linkValid == 1'b0, "R9 link idle in reset", linkValid, 0);
    chk(outValid == 1'b0, "R9 out idle in reset", outValid, 0);
    chk(inAck == '0, "R9 no ack in reset", inAck, 0);
  endtask

  task automatic testSingle();
    clearAll(); startAt();
    curD[2] = 16'h1234; load(2, curD[2]); addGroup(4'b0100);
    settle();
    compareAll("single");
    if (linkCyc.size() > 0 && ackCyc.size() > 0 && outCyc.size() > 0) begin
      chk(linkCyc[0] == ackCyc[0] + 1, "R1 link one cycle after ack", linkCyc[0], ackCyc[0] + 1);
      chk(outCyc[0] == linkCyc[0] + 1, "R8 pass-through latency", outCyc[0], linkCyc[0] + 1);
    end
  endtask

  task automatic testGroup(input logic [N-1:0] mask, input string tag);
    clearAll(); startAt();
    for (int i = 0; i < N; i++) begin
      curD[i] = W'(16'h3c01 * (i + 3) + cycle * 7);
      if (mask[i]) load(i, curD[i]);
    end
    addGroup(mask);
    settle();
    compareAll(tag);
    if (linkCyc.size() > 1 && outCyc.size() > 0)
      chk(outCyc[0] == linkCyc[1] + 1, {tag, " R7 first flit after second word"}, outCyc[0], linkCyc[1] + 1);
  endtask

  task automatic testLate();
    int fin;
    clearAll(); startAt();
    curD[0] = 16'haaaa; curD[1] = 16'h5a5a; curD[2] = 16'h0f0f; curD[3] = 16'h0;
    load(0, curD[0]); load(2, curD[2]);
    addGroup(4'b0101);
    @(negedge clk); #2;
    load(1, curD[1]);
    addGroup(4'b0010);
    settle();
    compareAll("late");
    if (linkCyc.size() == 3 && ackCyc.size() == 3) begin
      fin = linkCyc[1];
      chk(linkCyc[2] == fin + 2, "R4 one idle cycle after final word", linkCyc[2], fin + 2);
      chk(ackCyc[2] > ackCyc[1] + 1, "R6 late input held off", ackCyc[2], ackCyc[1] + 2);
    end else begin
      chk(0, "R6 late scenario word count", linkCyc.size(), 3);
    end
  endtask

  task automatic testBackToBack();
    clearAll(); startAt();
    for (int j = 0; j < 3; j++) begin
      logic [W-1:0] d;
      d = W'(16'h7100 + j);
      load(3, d);
    end
    for (int j = 0; j < 3; j++) begin
      curD[3] = W'(16'h7100 + j);
      addGroup(4'b1000);
    end
    settle();
    compareAll("burst");
    if (linkCyc.size() == 3) begin
      chk(linkCyc[1] == linkCyc[0] + 1, "R1 consecutive single words", linkCyc[1], linkCyc[0] + 1);
      chk(linkCyc[2] == linkCyc[1] + 1, "R1 consecutive single words", linkCyc[2], linkCyc[1] + 1);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      wrIdx[i] = 0; rdIdx[i] = 0; cnt[i] = 0;
      for (int j = 0; j < 8; j++) mem[i][j] = '0;
    end
    repeat (2) @(negedge clk);
    testReset();
    @(negedge clk); rstN = 1'b1;
    testSingle();                          // pointer moves to 3
    testGroup(4'b0011, "pair");            // R2 R3 R5
    testGroup(4'b1111, "all four");        // R2 R3 R4 R5 R7
    testGroup(4'b1101, "three");
    testGroup(4'b1010, "pair wrap");
    testLate();                            // R4 R6
    testBackToBack();                      // R1 R8
    testGroup(4'b0110, "pair again");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule